// File: doc/BRIEF.md
# UART Holding Buffer with Trigger Levels

This block is the byte store that sits between the host side of a UART and its serial shift register, in either the receive or the transmit direction. One side pushes bytes, the other pops them in arrival order, and the block reports its fill level, empty and full flags, and a sticky flag for bytes dropped at a full buffer. A two-bit select picks one of four thresholds. The trigger output compares the fill level against that threshold. A receive instance counts characters held. A transmit instance counts free spaces instead.

When the buffer is switched off, it degrades to a single holding byte kept in entry zero, so that a one-character-at-a-time UART still works. A one-cycle clear request empties the buffer and drops the overflow flag. A busy indication then stays high for a fixed number of cycles and falls by itself. While the request or busy is present, pushes and pops are refused. The attached shift register is not part of this block and a clear does not reach it.

Top module: `uart_hold_fifo`

## Requirements
- R1: After reset the level is 0, empty is 1, full is 0, overflow is 0, busy is 0 and pop data is 0x00; the trigger is 0 on a receive instance and 1 on a transmit instance with select 00.
- R2: With the buffer enabled, bytes leave in the order they were pushed; pop data and level change in the cycle after the clock edge that accepts the operation, a push adds one, a pop removes one, and both together leave the level unchanged.
- R3: When enabled, full is 1 exactly at level 64; a push alone at full is dropped, the level stays 64, and overflow becomes 1 and stays 1 until a clear.
- R4: A pop while empty leaves both the level and pop data unchanged.
- R5: On a receive instance, select 00/01/10/11 gives a threshold of 8/16/56/60 characters, and the trigger is 1 when the level is at or above it.
- R6: On a transmit instance, select 00/01/10/11 gives a threshold of 8/16/32/56 spaces, and the trigger is 1 when capacity minus level is at or above it.
- R7: With enable low, the capacity is one byte in entry zero. Full is 1 at level 1, and a second push is dropped and sets overflow. A pop returns the stored byte. Both trigger variants read 0.
- R8: A clear request empties the buffer and clears overflow at the next edge. Busy is then 1 for exactly 2 cycles and returns to 0 without further action.
- R9: Pushes and pops presented in the clear-request cycle or while busy is 1 are ignored.
- R10: A push and a pop together at full (enabled) are both accepted: the level stays 64 and overflow is not set.
- R11: A push and a pop together while empty accept only the push: the level becomes 1 and pop data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 64-entry buffer, 0 = single byte in entry zero |
| push | input | 1 | Write push_data this cycle |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte this cycle |
| pop_data | output | 8 | Last byte removed (registered) |
| trig_sel | input | 2 | Threshold select |
| clr_req | input | 1 | One-cycle clear command |
| clr_busy | output | 1 | Clear in progress; falls on its own |
| level | output | 7 | Bytes held |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level equals current capacity |
| overflow | output | 1 | Sticky: a push was dropped |
| trig | output | 1 | Threshold met (characters held or spaces free) |

## Verification
Level, flags, overflow, busy and pop data are all registered. Each one is due one edge after the edge that samples the stimulus, so the bench drives on the falling edge and reads a quarter period after the next rising edge. The trigger is a combinational function of the registered level and the select. It is therefore swept across all four selects between edges, and each value is read one time unit after the select changes. Busy is traced cycle by cycle after a clear, and the pushes made during those cycles are shown to be absent from the later pop data.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

    typedef enum logic {
        SIDE_RX = 1'b0,
        SIDE_TX = 1'b1
    } side_e;

    // Threshold for a select code, scaled from the buffer depth.
    function automatic int unsigned trig_level(side_e side, int unsigned depth, logic [1:0] sel);
        case (sel)
            2'd0:    return depth / 8;
            2'd1:    return depth / 4;
            2'd2:    return (side == SIDE_RX) ? depth - depth / 8  : depth / 2;
            default: return (side == SIDE_RX) ? depth - depth / 16 : depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/hfifo_clear.sv
module hfifo_clear #(
    parameter int unsigned CLR_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    output logic busy
);
    localparam int unsigned CW = $clog2(CLR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_req)
            cnt_d = CW'(CLR_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R8: a request always raises busy at the next edge
    assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> busy);

    // R8: busy falls on its own after the last counted cycle
    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && cnt_q == CW'(1)) |=> !busy);

endmodule

// File: rtl/hfifo_thresh.sv
module hfifo_thresh
    import hfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter side_e       SIDE  = SIDE_RX,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [LW-1:0] level,
    input  logic [1:0]    trig_sel,
    output logic          trig
);
    logic [LW-1:0] thr;

    always_comb thr = LW'(trig_level(SIDE, DEPTH, trig_sel));

    generate
        if (SIDE == SIDE_RX) begin : g_rx
            // characters held against threshold
            assign trig = (level >= thr);
        end else begin : g_tx
            logic [LW-1:0] cap;
            logic [LW-1:0] free;
            assign cap  = fifo_en ? LW'(DEPTH) : LW'(1);
            assign free = (level >= cap) ? '0 : cap - level;
            assign trig = (free >= thr);
        end
    endgenerate

    // R7: single-byte mode never meets any threshold
    assert_dis_no_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && level <= LW'(1)) |-> !trig);

endmodule

// File: rtl/hfifo_core.sv
module hfifo_core #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned LW    = $clog2(DEPTH + 1),
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             clr_req,
    input  logic             hold,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic [WIDTH-1:0] pop_data
);
    typedef struct packed {
        logic [AW-1:0]    wr;
        logic [AW-1:0]    rd;
        logic [LW-1:0]    lvl;
        logic             ovf;
        logic [WIDTH-1:0] pd;
    } st_t;

    st_t st_d, st_q;

    logic [WIDTH-1:0] mem_q [DEPTH];

    logic [LW-1:0] cap;
    logic          can_push, can_pop, lost;
    logic [AW-1:0] wr_addr, rd_addr;

    always_comb begin
        cap      = fifo_en ? LW'(DEPTH) : LW'(1);
        wr_addr  = fifo_en ? st_q.wr : '0;
        rd_addr  = fifo_en ? st_q.rd : '0;
        can_pop  = pop  && !hold && (st_q.lvl != '0);
        can_push = push && !hold && ((st_q.lvl < cap) || can_pop);
        lost     = push && !hold && !can_push;

        st_d = st_q;
        if (clr_req) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
            st_d.ovf = 1'b0;
        end else begin
            st_d.wr  = fifo_en ? st_q.wr + AW'(can_push) : '0;
            st_d.rd  = fifo_en ? st_q.rd + AW'(can_pop)  : '0;
            st_d.lvl = st_q.lvl + LW'(can_push) - LW'(can_pop);
            st_d.ovf = st_q.ovf | lost;
            if (can_pop) st_d.pd = mem_q[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (can_push) mem_q[wr_addr] <= push_data;
    end

    assign level    = st_q.lvl;
    assign full     = (st_q.lvl >= cap);
    assign empty    = (st_q.lvl == '0);
    assign overflow = st_q.ovf;
    assign pop_data = st_q.pd;

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full && !hold) |=> ($stable(level) && overflow));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr_req) |=> overflow);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty && !hold) |=> ($stable(level) && $stable(pop_data)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (level == '0 && !overflow));

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_req) |=> (level == '0));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

endmodule

// File: rtl/uart_hold_fifo.sv
module uart_hold_fifo
    import hfifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned CLR_CYCLES = 2,
    parameter side_e       SIDE       = SIDE_RX,
    localparam int unsigned LW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    input  logic [1:0]       trig_sel,
    input  logic             clr_req,
    output logic             clr_busy,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic             trig
);
    logic hold;

    assign hold = clr_req | clr_busy;

    hfifo_clear #(.CLR_CYCLES(CLR_CYCLES)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (clr_req),
        .busy    (clr_busy)
    );

    hfifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LW(LW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .clr_req   (clr_req),
        .hold      (hold),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .pop_data  (pop_data)
    );

    hfifo_thresh #(.DEPTH(DEPTH), .SIDE(SIDE), .LW(LW)) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .level    (level),
        .trig_sel (trig_sel),
        .trig     (trig)
    );

endmodule

// File: tb/sim_uart_hold_fifo.sv
module sim_uart_hold_fifo;
    import hfifo_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       push = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       clr_req = 1'b0;

    logic [7:0] pd_rx, pd_tx;
    logic       busy_rx, busy_tx;
    logic [6:0] lvl_rx, lvl_tx;
    logic       emp_rx, emp_tx, full_rx, full_tx, ovf_rx, ovf_tx, trig_rx, trig_tx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_hold_fifo #(.SIDE(SIDE_RX)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pd_rx), .trig_sel(trig_sel), .clr_req(clr_req),
        .clr_busy(busy_rx), .level(lvl_rx), .empty(emp_rx), .full(full_rx),
        .overflow(ovf_rx), .trig(trig_rx)
    );

    uart_hold_fifo #(.SIDE(SIDE_TX)) u1 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pd_tx), .trig_sel(trig_sel), .clr_req(clr_req),
        .clr_busy(busy_tx), .level(lvl_tx), .empty(emp_tx), .full(full_tx),
        .overflow(ovf_tx), .trig(trig_tx)
    );

    typedef struct packed {
        logic       p;
        logic       q;
        logic [7:0] d;
        logic [6:0] lvl;
        logic [7:0] pd;
    } vec_t;

    // R2, R4, R11 vectors: push, pop, data, expected level, expected pop data
    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 8'hA5, 7'd1, 8'h00},
        '{1'b1, 1'b0, 8'h3C, 7'd2, 8'h00},
        '{1'b1, 1'b1, 8'h7E, 7'd2, 8'hA5},
        '{1'b0, 1'b1, 8'h00, 7'd1, 8'h3C},
        '{1'b0, 1'b1, 8'h00, 7'd0, 8'h7E},
        '{1'b0, 1'b1, 8'h00, 7'd0, 8'h7E},
        '{1'b1, 1'b1, 8'h11, 7'd1, 8'h7E},
        '{1'b0, 1'b1, 8'h00, 7'd0, 8'h11}
    };

    localparam int RX_THR [4] = '{8, 16, 56, 60};
    localparam int TX_THR [4] = '{8, 16, 32, 56};

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at falling edge, sample a quarter period after the rising edge,
    // return at the next falling edge.
    task automatic cyc(logic p, logic q, logic [7:0] d, logic c);
        push = p; pop = q; push_data = d; clr_req = c;
        @(posedge clk);
        #(CLK_PERIOD / 4);
        push = 1'b0; pop = 1'b0; clr_req = 1'b0;
    endtask

    task automatic to_negedge();
        @(negedge clk);
    endtask

    task automatic sweep_trig(int lvl);
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            #1;
            check("R5", "rx trig", int'(trig_rx), int'(lvl >= RX_THR[s]));
            check("R6", "tx trig", int'(trig_tx), int'((64 - lvl) >= TX_THR[s]));
        end
        trig_sel = 2'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "level", int'(lvl_rx), 0);
        check("R1", "empty", int'(emp_rx), 1);
        check("R1", "full", int'(full_rx), 0);
        check("R1", "overflow", int'(ovf_rx), 0);
        check("R1", "busy", int'(busy_rx), 0);
        check("R1", "pop data", int'(pd_rx), 0);
        check("R1", "rx trig", int'(trig_rx), 0);
        check("R1", "tx trig", int'(trig_tx), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk
        for (int k = 0; k < 8; k++) begin
            cyc(VEC[k].p, VEC[k].q, VEC[k].d, 1'b0);
            check(VEC[k].p && VEC[k].q && k == 6 ? "R11" : (k == 5 ? "R4" : "R2"),
                  "level", int'(lvl_rx), int'(VEC[k].lvl));
            check(k == 5 ? "R4" : "R2", "pop data", int'(pd_rx), int'(VEC[k].pd));
            check("R2", "empty", int'(emp_rx), int'(VEC[k].lvl == 0));
            to_negedge();
        end

        // fill to 64, sweeping thresholds at every level
        sweep_trig(0);
        for (int i = 0; i < 64; i++) begin
            cyc(1'b1, 1'b0, pat(i), 1'b0);
            check("R2", "fill level", int'(lvl_rx), i + 1);
            check("R3", "full flag", int'(full_rx), int'(i == 63));
            to_negedge();
            sweep_trig(i + 1);
        end

        // R10: push and pop together at full
        cyc(1'b1, 1'b1, 8'hC3, 1'b0);
        check("R10", "level", int'(lvl_rx), 64);
        check("R10", "overflow", int'(ovf_rx), 0);
        check("R10", "pop data", int'(pd_rx), int'(pat(0)));
        to_negedge();

        // R3: push alone at full is dropped
        cyc(1'b1, 1'b0, 8'hEE, 1'b0);
        check("R3", "level", int'(lvl_rx), 64);
        check("R3", "overflow", int'(ovf_rx), 1);
        to_negedge();
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        check("R3", "overflow sticky", int'(ovf_rx), 1);
        to_negedge();

        // R2: drain in order; the dropped byte never appears
        for (int k = 0; k < 64; k++) begin
            cyc(1'b0, 1'b1, 8'h00, 1'b0);
            check("R2", "drain data", int'(pd_rx), k < 63 ? int'(pat(k + 1)) : 8'hC3);
            check("R2", "drain level", int'(lvl_rx), 63 - k);
            to_negedge();
        end
        check("R3", "overflow held", int'(ovf_rx), 1);

        // R8: clear with data present in enabled mode
        cyc(1'b1, 1'b0, 8'h01, 1'b0); to_negedge();
        cyc(1'b1, 1'b0, 8'h02, 1'b0); to_negedge();
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        check("R8", "level", int'(lvl_rx), 0);
        check("R8", "empty", int'(emp_rx), 1);
        check("R8", "overflow", int'(ovf_rx), 0);
        check("R8", "busy", int'(busy_rx), 1);
        to_negedge();
        cyc(1'b0, 1'b0, 8'h00, 1'b0); check("R8", "busy c2", int'(busy_rx), 1); to_negedge();
        cyc(1'b0, 1'b0, 8'h00, 1'b0); check("R8", "busy c3", int'(busy_rx), 0); to_negedge();

        // R7: single-byte mode
        fifo_en = 1'b0;
        cyc(1'b1, 1'b0, 8'h21, 1'b0);
        check("R7", "level", int'(lvl_rx), 1);
        check("R7", "full", int'(full_rx), 1);
        to_negedge();
        #1;
        check("R7", "rx trig", int'(trig_rx), 0);
        check("R7", "tx trig", int'(trig_tx), 0);
        cyc(1'b1, 1'b0, 8'h22, 1'b0);
        check("R7", "level after drop", int'(lvl_rx), 1);
        check("R7", "overflow", int'(ovf_rx), 1);
        to_negedge();
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        check("R7", "pop data", int'(pd_rx), 8'h21);
        check("R7", "level", int'(lvl_rx), 0);
        to_negedge();
        #1;
        check("R7", "tx trig empty", int'(trig_tx), 0);

        // R9: pushes in the request cycle and while busy are ignored
        cyc(1'b1, 1'b0, 8'h44, 1'b1);
        check("R9", "level req cycle", int'(lvl_rx), 0);
        check("R8", "overflow cleared", int'(ovf_rx), 0);
        check("R8", "busy", int'(busy_rx), 1);
        to_negedge();
        cyc(1'b1, 1'b0, 8'h55, 1'b0);
        check("R9", "level busy1", int'(lvl_rx), 0);
        check("R8", "busy", int'(busy_rx), 1);
        to_negedge();
        cyc(1'b1, 1'b0, 8'h66, 1'b0);
        check("R9", "level busy2", int'(lvl_rx), 0);
        check("R8", "busy fell", int'(busy_rx), 0);
        to_negedge();
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        check("R9", "pop ignored data", int'(pd_rx), 8'h21);
        to_negedge();
        cyc(1'b1, 1'b0, 8'h77, 1'b0);
        check("R9", "push accepted", int'(lvl_rx), 1);
        to_negedge();
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        check("R9", "pop data", int'(pd_rx), 8'h77);
        check("R7", "tx pop data", int'(pd_tx), 8'h77);
        to_negedge();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule